// File: doc/BRIEF.md
# Registered Sixteen-Operation ALU

This block is a single-stage arithmetic-logic unit. On each rising clock edge it samples two operands, a 4-bit operation code and a synchronous clear input. It then registers a result word together with carry, overflow and zero flags. Sixteen operations are available:

- arithmetic on both operands: sum, difference, product
- single-operand steps: increment or decrement of either operand
- a flag-only compare
- circular rotation of the first operand in either direction
- bitwise logic and complements
- a conditional clear that zeroes the result only when the operands match

Typical use is as the execute stage of a small datapath. The controller presents operands and an operation code each cycle and reads the result and flags one cycle later. Compare and a non-matching conditional clear leave the result register untouched, so a value can be kept across flag-only steps. The data width is a parameter (`DW`, default 8); the operation code is always 4 bits.

Top module: `reg_alu16`

## Requirements
- R1: With `rst_n` low at a rising edge, `res_y` becomes zero and `flag_c`, `flag_v`, `flag_z` become 0.
- R2: With `clr` high at a rising edge and `rst_n` high, `res_y`, `flag_c`, `flag_v` and `flag_z` all become 0, whatever the operation code.
- R3: Sum (code 0) gives A+B modulo 2^DW with C = carry out. Difference (code 3) gives A-B modulo 2^DW with C = borrow (A < B unsigned). For both, V = signed two's-complement overflow.
- R4: Increment A (1), increment B (2), decrement A (8) and decrement B (9) wrap modulo 2^DW. C is the carry out for increment and the borrow for decrement. V is signed overflow (increment of 0x7F, decrement of 0x80).
- R5: Compare (code 4) leaves `res_y` unchanged. It sets C to the borrow of A-B and V to the signed overflow of A-B. It sets Z exactly when A equals B.
- R6: Rotate-left (code 5) and rotate-right (code 6) rotate A circularly by B[log2(DW)-1:0] positions (B[2:0] for DW=8), with C=0 and V=0.
- R7: Conditional clear (code 7) sets `res_y` to zero when A equals B and otherwise leaves `res_y` unchanged. C=0 and V=0.
- R8: Multiply (code 10) gives the low DW bits of the unsigned product A*B. C=1 when the high DW bits are nonzero. V=0.
- R9: Complement A (11), AND (12), OR (13), XOR (14) and complement B (15) give bitwise results with C=0 and V=0.
- R10: For every operation other than compare, Z equals 1 exactly when the newly registered `res_y` is zero.
- R11: The operation codes are: sum=0, inc A=1, inc B=2, difference=3, compare=4, rotate-left=5, rotate-right=6, conditional clear=7, dec A=8, dec B=9, multiply=10, complement A=11, AND=12, OR=13, XOR=14, complement B=15.
- R12: Inputs sampled at a rising edge are reflected at the outputs right after that same edge: one register, no further latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of result and flags, active high |
| op_a | input | DW | First operand |
| op_b | input | DW | Second operand |
| op_sel | input | 4 | Operation code |
| res_y | output | DW | Registered result |
| flag_c | output | 1 | Carry or borrow flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_z | output | 1 | Zero flag (operand equality for compare) |

## Verification
The bench builds the block at its default width, DW=8. At that width the rotate amount is three bits and the signed boundaries 0x7F and 0x80 can be driven directly. The all-ones and zero wrap points and products spilling into the high byte are also reachable by directed stimulus. A randomised phase then covers all sixteen codes against an independent model. That model includes the held result for compare and for a non-matching conditional clear, and the priority of `clr` over the operation.

// File: rtl/alu16_pkg.sv
`timescale 1ns/1ps
// Package: shared operation codes for the registered ALU.
// Assumes a fixed 4-bit operation field; the code order is part of the
// interface seen by whatever drives op_sel.
package alu16_pkg;

    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,
        OP_INCA = 4'd1,
        OP_INCB = 4'd2,
        OP_SUB  = 4'd3,
        OP_CMP  = 4'd4,
        OP_ROTL = 4'd5,
        OP_ROTR = 4'd6,
        OP_CLRC = 4'd7,
        OP_DECA = 4'd8,
        OP_DECB = 4'd9,
        OP_MUL  = 4'd10,
        OP_CPLA = 4'd11,
        OP_AND  = 4'd12,
        OP_OR   = 4'd13,
        OP_XOR  = 4'd14,
        OP_CPLB = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic v;
    } cv_flags_t;

endpackage

// File: rtl/alu16_addsub.sv
`timescale 1ns/1ps
// Module: alu16_addsub
// One shared adder serving sum, difference, compare, increments and
// decrements. It picks the operand pair and direction from the operation code.
// Assumes the caller only uses its outputs for those seven codes.
module alu16_addsub
    import alu16_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  alu_op_e       op_i,
    output logic [DW-1:0] sum_o,
    output cv_flags_t     cv_o
);

    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    logic [DW-1:0] x_opd;
    logic [DW-1:0] y_opd;
    logic [DW-1:0] y_eff;
    logic          do_sub;
    logic [DW:0]   sum_w;

    // Purpose: pick adder operands and direction for the requested operation.
    always_comb begin
        x_opd  = a_i;
        y_opd  = b_i;
        do_sub = 1'b0;
        case (op_i)
            OP_ADD:          begin x_opd = a_i; y_opd = b_i; do_sub = 1'b0; end
            OP_INCA:         begin x_opd = a_i; y_opd = ONE; do_sub = 1'b0; end
            OP_INCB:         begin x_opd = b_i; y_opd = ONE; do_sub = 1'b0; end
            OP_SUB, OP_CMP:  begin x_opd = a_i; y_opd = b_i; do_sub = 1'b1; end
            OP_DECA:         begin x_opd = a_i; y_opd = ONE; do_sub = 1'b1; end
            OP_DECB:         begin x_opd = b_i; y_opd = ONE; do_sub = 1'b1; end
            default:         begin x_opd = a_i; y_opd = b_i; do_sub = 1'b0; end
        endcase
    end

    // Purpose: single carry chain; subtraction as x + ~y + 1.
    always_comb begin
        y_eff = do_sub ? ~y_opd : y_opd;
        sum_w = {1'b0, x_opd} + {1'b0, y_eff} + {{DW{1'b0}}, do_sub};
        sum_o = sum_w[DW-1:0];
        cv_o.c = do_sub ? ~sum_w[DW] : sum_w[DW];
        cv_o.v = (x_opd[DW-1] == y_eff[DW-1]) && (sum_w[DW-1] != x_opd[DW-1]);
    end

endmodule

// File: rtl/alu16_rotator.sv
`timescale 1ns/1ps
// Module: alu16_rotator
// Logarithmic barrel rotator, one stage per bit of the rotate amount.
// The parameter LEFT selects the direction. Assumes DW is a power of two,
// so the amount wraps naturally at DW positions.
module alu16_rotator #(
    parameter int DW   = 8,
    parameter bit LEFT = 1'b1,
    localparam int SHW = $clog2(DW)
) (
    input  logic [DW-1:0]  data_i,
    input  logic [SHW-1:0] amt_i,
    output logic [DW-1:0]  data_o
);

    logic [DW-1:0] stage [0:SHW];

    assign stage[0] = data_i;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int S = 1 << k;
        if (LEFT) begin : g_left
            // Purpose: rotate left by 2^k when amount bit k is set.
            assign stage[k+1] = amt_i[k] ? {stage[k][DW-1-S:0], stage[k][DW-1:DW-S]}
                                         : stage[k];
        end else begin : g_right
            // Purpose: rotate right by 2^k when amount bit k is set.
            assign stage[k+1] = amt_i[k] ? {stage[k][S-1:0], stage[k][DW-1:S]}
                                         : stage[k];
        end
    end

    assign data_o = stage[SHW];

endmodule

// File: rtl/alu16_bitwise.sv
`timescale 1ns/1ps
// Module: alu16_bitwise
// Bitwise logic and complement operations plus the unsigned multiplier.
// Assumes the result is only consumed for the matching operation codes.
module alu16_bitwise
    import alu16_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  alu_op_e       op_i,
    output logic [DW-1:0] logic_o,
    output logic [DW-1:0] prod_lo_o,
    output logic          prod_hi_nz_o
);

    logic [2*DW-1:0] product;

    // Purpose: bitwise result for the five logic codes.
    always_comb begin
        case (op_i)
            OP_CPLA: logic_o = ~a_i;
            OP_CPLB: logic_o = ~b_i;
            OP_AND:  logic_o = a_i & b_i;
            OP_OR:   logic_o = a_i | b_i;
            OP_XOR:  logic_o = a_i ^ b_i;
            default: logic_o = '0;
        endcase
    end

    // Purpose: full-width unsigned product, split into low word and high-nonzero.
    always_comb begin
        product      = {{DW{1'b0}}, a_i} * {{DW{1'b0}}, b_i};
        prod_lo_o    = product[DW-1:0];
        prod_hi_nz_o = |product[2*DW-1:DW];
    end

endmodule

// File: rtl/reg_alu16.sv
`timescale 1ns/1ps
// Module: reg_alu16 (top)
// Single-stage registered ALU with sixteen operations. It combines the
// shared adder, two rotators and the bitwise/multiply unit, then registers
// the result and flags. Assumes DW is a power of two and at least 4.
// rst_n is synchronous active-low; clr is a synchronous active-high clear.
module reg_alu16
    import alu16_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic [3:0]    op_sel,
    output logic [DW-1:0] res_y,
    output logic          flag_c,
    output logic          flag_v,
    output logic          flag_z
);

    localparam int SHW = $clog2(DW);

    alu_op_e       op;
    logic [DW-1:0] as_sum;
    cv_flags_t     as_cv;
    logic [DW-1:0] rot_l;
    logic [DW-1:0] rot_r;
    logic [DW-1:0] bw_y;
    logic [DW-1:0] mul_lo;
    logic          mul_hi_nz;
    logic          opd_eq;
    logic [DW-1:0] y_nxt;
    logic          c_nxt;
    logic          v_nxt;
    logic          z_nxt;

    assign op     = alu_op_e'(op_sel);
    assign opd_eq = (op_a == op_b);

    alu16_addsub #(.DW(DW)) u_addsub (
        .a_i   (op_a),
        .b_i   (op_b),
        .op_i  (op),
        .sum_o (as_sum),
        .cv_o  (as_cv)
    );

    alu16_rotator #(.DW(DW), .LEFT(1'b1)) u_rotl (
        .data_i (op_a),
        .amt_i  (op_b[SHW-1:0]),
        .data_o (rot_l)
    );

    alu16_rotator #(.DW(DW), .LEFT(1'b0)) u_rotr (
        .data_i (op_a),
        .amt_i  (op_b[SHW-1:0]),
        .data_o (rot_r)
    );

    alu16_bitwise #(.DW(DW)) u_bitwise (
        .a_i          (op_a),
        .b_i          (op_b),
        .op_i         (op),
        .logic_o      (bw_y),
        .prod_lo_o    (mul_lo),
        .prod_hi_nz_o (mul_hi_nz)
    );

    // Purpose: choose next result and carry/overflow for the decoded operation.
    always_comb begin
        y_nxt = res_y;
        c_nxt = 1'b0;
        v_nxt = 1'b0;
        case (op)
            OP_ADD, OP_INCA, OP_INCB, OP_SUB, OP_DECA, OP_DECB: begin
                y_nxt = as_sum;
                c_nxt = as_cv.c;
                v_nxt = as_cv.v;
            end
            OP_CMP: begin
                y_nxt = res_y;
                c_nxt = as_cv.c;
                v_nxt = as_cv.v;
            end
            OP_ROTL: y_nxt = rot_l;
            OP_ROTR: y_nxt = rot_r;
            OP_CLRC: y_nxt = opd_eq ? '0 : res_y;
            OP_MUL: begin
                y_nxt = mul_lo;
                c_nxt = mul_hi_nz;
            end
            OP_CPLA, OP_AND, OP_OR, OP_XOR, OP_CPLB: y_nxt = bw_y;
            default: y_nxt = res_y;
        endcase
    end

    // Purpose: zero flag reflects equality for compare, else the new result.
    always_comb begin
        z_nxt = (op == OP_CMP) ? opd_eq : (y_nxt == '0);
    end

    // Purpose: the single pipeline register; reset beats clear beats operation.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            res_y  <= '0;
            flag_c <= 1'b0;
            flag_v <= 1'b0;
            flag_z <= 1'b0;
        end else begin
            res_y  <= y_nxt;
            flag_c <= c_nxt;
            flag_v <= v_nxt;
            flag_z <= z_nxt;
        end
    end

endmodule

// File: rtl/reg_alu16_chk.sv
`timescale 1ns/1ps
// Module: reg_alu16_chk
// Temporal checks on the registered ALU ports, bound into every instance.
module reg_alu16_chk
    import alu16_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr,
    input logic [DW-1:0] op_a,
    input logic [DW-1:0] op_b,
    input logic [3:0]    op_sel,
    input logic [DW-1:0] res_y,
    input logic          flag_c,
    input logic          flag_v,
    input logic          flag_z
);

    logic go;
    logic flagless;
    assign go       = !clr;
    assign flagless = (op_sel == OP_ROTL) || (op_sel == OP_ROTR) || (op_sel == OP_CLRC);

    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (res_y == '0 && !flag_c && !flag_v && !flag_z)); // R2

    AST_CMP_HOLDS_Y: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_sel == OP_CMP) |=> $stable(res_y)); // R5

    AST_ROT_NO_CV: assert property (@(posedge clk) disable iff (!rst_n)
        (go && flagless) |=> (!flag_c && !flag_v)); // R6

    AST_CLRC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_sel == OP_CLRC && op_a == op_b) |=> (res_y == '0)); // R7

    AST_CLRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_sel == OP_CLRC && op_a != op_b) |=> $stable(res_y)); // R7

    AST_MUL_NO_V: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_sel == OP_MUL) |=> !flag_v); // R8

    AST_LOGIC_NO_CV: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_sel >= OP_CPLA) |=> (!flag_c && !flag_v)); // R9

    AST_Z_TRACKS_Y: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_sel != OP_CMP) |=> (flag_z == (res_y == '0))); // R10

endmodule

bind reg_alu16 reg_alu16_chk #(.DW(DW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .op_a   (op_a),
    .op_b   (op_b),
    .op_sel (op_sel),
    .res_y  (res_y),
    .flag_c (flag_c),
    .flag_v (flag_v),
    .flag_z (flag_z)
);

// File: tb/reg_alu16_tb.sv
`timescale 1ns/1ps
// Scoreboard bench for reg_alu16 at DW=8: the driver pushes expected
// results, the monitor pops and compares them after each rising edge.
module reg_alu16_tb;

    localparam int CODE_ADD = 0,  CODE_INCA = 1, CODE_INCB = 2,  CODE_SUB = 3;
    localparam int CODE_CMP = 4,  CODE_ROTL = 5, CODE_ROTR = 6,  CODE_CLRC = 7;
    localparam int CODE_DECA = 8, CODE_DECB = 9, CODE_MUL = 10,  CODE_CPLA = 11;
    localparam int CODE_AND = 12, CODE_OR = 13,  CODE_XOR = 14,  CODE_CPLB = 15;

    typedef struct {
        int    y;
        bit    c;
        bit    v;
        bit    z;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic [7:0] op_a = '0;
    logic [7:0] op_b = '0;
    logic [3:0] op_sel = '0;
    logic [7:0] res_y;
    logic       flag_c, flag_v, flag_z;

    int   tests = 0;
    int   fails = 0;
    int   model_y = 0;
    exp_t sb[$];

    always #4 clk = ~clk;

    reg_alu16 #(.DW(8)) u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .op_a   (op_a),
        .op_b   (op_b),
        .op_sel (op_sel),
        .res_y  (res_y),
        .flag_c (flag_c),
        .flag_v (flag_v),
        .flag_z (flag_z)
    );

    function automatic int sx(input int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    function automatic bit out_of_range(input int s);
        return (s > 127) || (s < -128);
    endfunction

    // Driver: apply one operation at the falling edge and queue its expected outcome.
    task automatic drive(input int a, input int b, input int code,
                         input bit clr_in, input bit rst_in, input string tag);
        exp_t e;
        int   amt, p, x;
        @(negedge clk);
        op_a = 8'(a); op_b = 8'(b); op_sel = 4'(code);
        clr = clr_in; rst_n = !rst_in;
        e.tag = tag; e.y = model_y; e.c = 0; e.v = 0;
        amt = b % 8;
        x = (code == CODE_INCB || code == CODE_DECB) ? b : a;
        case (code)
            CODE_ADD:  begin e.y = (a + b) & 255; e.c = (a + b) > 255; e.v = out_of_range(sx(a) + sx(b)); end
            CODE_SUB:  begin e.y = (a - b) & 255; e.c = a < b;         e.v = out_of_range(sx(a) - sx(b)); end
            CODE_CMP:  begin e.y = model_y;       e.c = a < b;         e.v = out_of_range(sx(a) - sx(b)); end
            CODE_INCA, CODE_INCB: begin e.y = (x + 1) & 255; e.c = (x == 255); e.v = (x == 127); end
            CODE_DECA, CODE_DECB: begin e.y = (x - 1) & 255; e.c = (x == 0);   e.v = (x == 128); end
            CODE_ROTL: e.y = ((a << amt) | (a >> (8 - amt))) & 255;
            CODE_ROTR: e.y = ((a >> amt) | (a << (8 - amt))) & 255;
            CODE_CLRC: e.y = (a == b) ? 0 : model_y;
            CODE_MUL:  begin p = a * b; e.y = p & 255; e.c = p > 255; end
            CODE_CPLA: e.y = (~a) & 255;
            CODE_CPLB: e.y = (~b) & 255;
            CODE_AND:  e.y = a & b;
            CODE_OR:   e.y = a | b;
            CODE_XOR:  e.y = a ^ b;
            default:   e.y = model_y;
        endcase
        e.z = (code == CODE_CMP) ? (a == b) : (e.y == 0);
        if (clr_in || rst_in) begin
            e.y = 0; e.c = 0; e.v = 0; e.z = 0;
        end
        model_y = e.y;
        sb.push_back(e);
    endtask

    // Monitor: after each rising edge, compare the outputs with the oldest queued item.
    always @(posedge clk) begin
        exp_t e;
        #2;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            tests++;
            if (res_y !== 8'(e.y) || flag_c !== e.c || flag_v !== e.v || flag_z !== e.z) begin
                fails++;
                $display("FAIL %s: y=%02h c=%b v=%b z=%b expected y=%02h c=%b v=%b z=%b",
                         e.tag, res_y, flag_c, flag_v, flag_z, 8'(e.y), e.c, e.v, e.z);
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(20000 * 8);
        tests++; fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tests++;
        if (res_y !== 8'h00 || flag_c !== 1'b0 || flag_v !== 1'b0 || flag_z !== 1'b0) begin
            fails++;
            $display("FAIL R1: y=%02h c=%b v=%b z=%b expected all zero", res_y, flag_c, flag_v, flag_z);
        end
        // R3 sum and difference corners
        drive(8'h10, 8'h20, CODE_ADD, 0, 0, "R3 add plain");
        drive(8'h7F, 8'h01, CODE_ADD, 0, 0, "R3 add signed ovf");
        drive(8'hFF, 8'h01, CODE_ADD, 0, 0, "R3 add carry wrap R10");
        drive(8'h05, 8'h07, CODE_SUB, 0, 0, "R3 sub borrow");
        drive(8'h80, 8'h01, CODE_SUB, 0, 0, "R3 sub signed ovf");
        // R4 increments and decrements
        drive(8'h7F, 8'h00, CODE_INCA, 0, 0, "R4 inca ovf R11");
        drive(8'h00, 8'hFF, CODE_INCB, 0, 0, "R4 incb wrap");
        drive(8'h00, 8'h00, CODE_DECA, 0, 0, "R4 deca borrow");
        drive(8'h11, 8'h80, CODE_DECB, 0, 0, "R4 decb ovf");
        // R5 compare holds result (currently 0x7F)
        drive(8'h33, 8'h33, CODE_CMP, 0, 0, "R5 cmp equal");
        drive(8'h02, 8'h90, CODE_CMP, 0, 0, "R5 cmp below");
        // R6 rotations
        drive(8'h81, 8'h09, CODE_ROTL, 0, 0, "R6 rotl amt1 from B[2:0]");
        drive(8'h01, 8'h03, CODE_ROTR, 0, 0, "R6 rotr by 3");
        drive(8'hA5, 8'h08, CODE_ROTL, 0, 0, "R6 rotl amt0");
        // R7 conditional clear
        drive(8'h12, 8'h34, CODE_CLRC, 0, 0, "R7 clrc mismatch hold");
        drive(8'h5A, 8'h5A, CODE_CLRC, 0, 0, "R7 clrc match zero");
        // R8 multiply
        drive(8'h10, 8'h10, CODE_MUL, 0, 0, "R8 mul high only");
        drive(8'h03, 8'h05, CODE_MUL, 0, 0, "R8 mul small");
        // R9 logic
        drive(8'hF0, 8'h3C, CODE_AND, 0, 0, "R9 and");
        drive(8'hF0, 8'h0F, CODE_OR,  0, 0, "R9 or");
        drive(8'hAA, 8'hAA, CODE_XOR, 0, 0, "R9 xor zero R10");
        drive(8'h0F, 8'h00, CODE_CPLA, 0, 0, "R9 cpla");
        drive(8'h00, 8'hFF, CODE_CPLB, 0, 0, "R9 cplb zero");
        // R2 clear beats operation; R1 mid-run reset
        drive(8'h40, 8'h40, CODE_ADD, 1, 0, "R2 clr over add");
        drive(8'h7F, 8'h7F, CODE_ADD, 0, 0, "R12 after clr");
        drive(8'h01, 8'h01, CODE_SUB, 0, 1, "R1 mid-run reset");
        drive(8'h22, 8'h01, CODE_CLRC, 0, 0, "R7 hold after reset");
        for (int i = 0; i < 400; i++) begin
            drive(int'($urandom_range(255)), int'($urandom_range(255)),
                  int'($urandom_range(15)), ($urandom_range(15) == 0), 1'b0, "R12 random");
        end
        @(negedge clk);
        clr = 1'b0;
        wait (sb.size() == 0);
        repeat (2) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule